// File: doc/BRIEF.md
# Reset Cause Register with Software Reset Trigger

This block holds a 32-bit register that records why the system last came out of reset, and lets software ask for a new system reset by writing to it. The top five bits carry meaning. Bit 31 marks a power-on reset, bit 30 a software power-on request and bit 29 a software externally-initiated reset. Bits 28 and 27 are the two button causes, power-on and externally-initiated. Bits 31, 28 and 27 are cleared by writing 1. Bits 30 and 29 are set by writing 1. All lower bits read as zero and ignore writes.

An internal arm flag decides whether the next system reset counts as a power-on reset. The power-up reset sets the flag. The first system reset after that loads the register with exactly 0x80000000 and consumes the flag. A software power-on request sets the flag again. Any system reset that finds the flag clear leaves the register untouched. Software requests come out as a registered one-cycle pulse. The system is expected to answer that pulse by asserting the reset input. The register sits in a small address window, and only the upper 32-bit word of that window reaches it.

Top module: `rst_cause_reg`

## Requirements
- R1: After the power-up reset, the register reads 0x00000000 and `resetReq` is low.
- R2: The first `sysRst` cycle after the power-up reset loads the register with exactly 0x80000000. A later `sysRst` with no re-arm in between leaves the register unchanged.
- R3: A write with a 1 in bit 31, 28 or 27 clears that bit. A 0 in those positions leaves the bit as it was.
- R4: A write with a 1 in bit 30 or 29 sets that bit. A 0 in those positions leaves the bit as it was.
- R5: Write data bits 26:0 have no effect, and those bits always read 0.
- R6: A write with bit 30 set pulses `resetReq` high for exactly the one cycle after the write edge. It also re-arms the flag, so the next `sysRst` loads 0x80000000 again.
- R7: A write with bit 29 set and bit 30 clear pulses `resetReq` for one cycle but does not re-arm the flag. The next `sysRst` leaves the register unchanged.
- R8: The register is selected only when `addr[15:3]` equals 0x1E04 (byte offset 0xF020) and `addr[2]` is 1. At the lower word (0xF020), or at any other address, reads return 0 and writes are ignored.
- R9: When `sysRst` is high in the same cycle as a write, the write is ignored: no bit changes, no re-arm and no request.
- R10: A selected write with bits 30 and 29 both clear produces no `resetReq` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwrOnRst_n | input | 1 | Asynchronous power-up reset, active low; sets the arm flag |
| sysRst | input | 1 | System reset, synchronous, active high |
| wrEn | input | 1 | Write strobe |
| addr | input | 16 | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The clear-on-one and set-on-one behaviour is tested in several ways:
- An all-zero write shows that a 0 leaves every bit alone.
- A write of 0x98000000 shows the clear path.
- Separate writes to bits 29 and 30 show the set path and which request each one triggers.
- A write of 0x07FFFFFF shows the low bits are masked.

Reset sequences separate a re-arming write from a non-re-arming one by checking whether the following `sysRst` reloads 0x80000000. Writes to the lower word and to a neighbouring address test the decode. A write made in the same cycle as `sysRst` tests the priority between the two.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 16;
  localparam logic [ADDR_W-1:0] REG_BASE = 16'hF020;

  localparam int PWR_BIT   = DATA_W - 1;
  localparam int SWPWR_BIT = DATA_W - 2;
  localparam int SWEXT_BIT = DATA_W - 3;
  localparam int BTPWR_BIT = DATA_W - 4;
  localparam int BTEXT_BIT = DATA_W - 5;

  localparam logic [DATA_W-1:0] CLR_MASK =
    (DATA_W'(1) << PWR_BIT) | (DATA_W'(1) << BTPWR_BIT) | (DATA_W'(1) << BTEXT_BIT);
  localparam logic [DATA_W-1:0] SET_MASK =
    (DATA_W'(1) << SWPWR_BIT) | (DATA_W'(1) << SWEXT_BIT);
  localparam logic [DATA_W-1:0] LIVE_MASK = CLR_MASK | SET_MASK;
  localparam logic [DATA_W-1:0] PWR_ONLY  = DATA_W'(1) << PWR_BIT;

  typedef struct packed {
    logic regWr;
    logic pwrLoad;
  } rcStrobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              pwrOnRst_n,
  input  logic              sysRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              swPwrBit,
  input  logic              swExtBit,
  output rcStrobe_t         stb,
  output logic              regSel,
  output logic              resetReq
);
  localparam int WORD_LSB = 3;

  logic armed;

  assign regSel = (addr[ADDR_W-1:WORD_LSB] == REG_BASE[ADDR_W-1:WORD_LSB]) && addr[2];

  always_comb begin
    stb.regWr   = wrEn && regSel && !sysRst;
    stb.pwrLoad = sysRst && armed;
  end

  always_ff @(posedge clk or negedge pwrOnRst_n) begin
    if (!pwrOnRst_n) begin
      armed    <= 1'b1;
      resetReq <= 1'b0;
    end else begin
      resetReq <= stb.regWr && (swPwrBit || swExtBit);
      if (sysRst)
        armed <= 1'b0;
      else if (stb.regWr && swPwrBit)
        armed <= 1'b1;
    end
  end

  // R6
  swpwr_req_chk: assert property (@(posedge clk) disable iff (!pwrOnRst_n)
    (wrEn && regSel && !sysRst && swPwrBit) |=> resetReq);

  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!pwrOnRst_n)
    (wrEn && regSel && !sysRst && swPwrBit) |=> armed);

  // R9
  rst_blocks_req_chk: assert property (@(posedge clk) disable iff (!pwrOnRst_n)
    (sysRst && !$past(wrEn)) |-> !stb.regWr);
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              pwrOnRst_n,
  input  rcStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusQ
);
  logic [DATA_W-1:0] wrVal;

  assign wrVal = wrData & LIVE_MASK;

  always_ff @(posedge clk or negedge pwrOnRst_n) begin
    if (!pwrOnRst_n)
      statusQ <= '0;
    else if (stb.pwrLoad)
      statusQ <= PWR_ONLY;
    else if (stb.regWr)
      statusQ <= (statusQ & ~(wrVal & CLR_MASK)) | (wrVal & SET_MASK);
  end

  // R2
  pwr_load_chk: assert property (@(posedge clk) disable iff (!pwrOnRst_n)
    stb.pwrLoad |=> (statusQ == PWR_ONLY));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!pwrOnRst_n)
    (!stb.pwrLoad && !stb.regWr) |=> $stable(statusQ));

  // R5
  low_zero_chk: assert property (@(posedge clk) disable iff (!pwrOnRst_n)
    (statusQ & ~LIVE_MASK) == '0);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              pwrOnRst_n,
  input  logic              sysRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              resetReq
);
  rcStrobe_t         stb;
  logic              regSel;
  logic [DATA_W-1:0] statusQ;

  rst_cause_ctrl u_ctrl (
    .clk(clk), .pwrOnRst_n(pwrOnRst_n), .sysRst(sysRst), .wrEn(wrEn),
    .addr(addr), .swPwrBit(wrData[SWPWR_BIT]), .swExtBit(wrData[SWEXT_BIT]),
    .stb(stb), .regSel(regSel), .resetReq(resetReq)
  );

  rst_cause_dp u_dp (
    .clk(clk), .pwrOnRst_n(pwrOnRst_n), .stb(stb), .wrData(wrData),
    .statusQ(statusQ)
  );

  assign rdData = regSel ? statusQ : '0;

  // R6
  req_after_write_chk: assert property (@(posedge clk) disable iff (!pwrOnRst_n)
    resetReq |-> $past(wrEn));
endmodule

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
  logic        clk = 1'b0;
  logic        pwrOnRst_n = 1'b0;
  logic        sysRst = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        resetReq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [15:0] HI = 16'hF024;
  localparam logic [15:0] LO = 16'hF020;

  always #10 clk = ~clk;

  rst_cause_reg u0 (.clk(clk), .pwrOnRst_n(pwrOnRst_n), .sysRst(sysRst),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .resetReq(resetReq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  // write; checks the request pulse in the cycle after the write and the one after that
  task automatic wr(input string tag, input logic [15:0] a, input logic [31:0] d, input bit expReq);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = 32'h0;
    chk({tag, " req"}, {31'h0, resetReq}, {31'h0, expReq});
    @(negedge clk);
    chk({tag, " req end"}, {31'h0, resetReq}, 32'h0);
  endtask

  task automatic pulse_rst();
    @(negedge clk);
    sysRst = 1'b1;
    @(negedge clk);
    sysRst = 1'b0;
  endtask

  task automatic t_powerup();
    rd("R1 status", HI, 32'h0);
    chk("R1 req", {31'h0, resetReq}, 32'h0);
  endtask

  task automatic t_first_rst();
    pulse_rst();
    rd("R2 first", HI, 32'h80000000);
    pulse_rst();
    rd("R2 later", HI, 32'h80000000);
  endtask

  task automatic t_decode();
    wr("R8 lower", LO, 32'hFFFFFFFF, 1'b0);
    rd("R8 upper kept", HI, 32'h80000000);
    rd("R8 lower read", LO, 32'h0);
    wr("R8 other", 16'hF02C, 32'hFFFFFFFF, 1'b0);
    rd("R8 other kept", HI, 32'h80000000);
    rd("R8 alias read", 16'h0024, 32'h0);
  endtask

  task automatic t_clear();
    wr("R10 zero", HI, 32'h0, 1'b0);
    rd("R3 zero keeps", HI, 32'h80000000);
    wr("R3 clr", HI, 32'h98000000, 1'b0);
    rd("R3 cleared", HI, 32'h0);
  endtask

  task automatic t_ext();
    wr("R7 ext", HI, 32'h20000000, 1'b1);
    rd("R4 ext set", HI, 32'h20000000);
    wr("R4 zero", HI, 32'h0, 1'b0);
    rd("R4 kept", HI, 32'h20000000);
    pulse_rst();
    rd("R7 no rearm", HI, 32'h20000000);
    wr("R5 low", HI, 32'h07FFFFFF, 1'b0);
    rd("R5 masked", HI, 32'h20000000);
  endtask

  task automatic t_swpwr();
    wr("R6 swpwr", HI, 32'h40000000, 1'b1);
    rd("R6 set", HI, 32'h60000000);
    pulse_rst();
    rd("R6 rearm load", HI, 32'h80000000);
    pulse_rst();
    rd("R6 consumed", HI, 32'h80000000);
  endtask

  task automatic t_priority();
    wr("R4 ext again", HI, 32'h20000000, 1'b1);
    @(negedge clk);
    addr = HI; wrData = 32'hC0000000; wrEn = 1'b1; sysRst = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; sysRst = 1'b0; wrData = 32'h0;
    chk("R9 no req", {31'h0, resetReq}, 32'h0);
    rd("R9 unchanged", HI, 32'hA0000000);
    pulse_rst();
    rd("R9 no rearm", HI, 32'hA0000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_powerup();
    pwrOnRst_n = 1'b1;
    @(negedge clk);
    t_powerup();
    t_first_rst();
    t_decode();
    t_clear();
    t_ext();
    t_swpwr();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule